// File: doc/BRIEF.md
# Tag Check Fault Policy Unit

This block decides what a processor does after a memory tag check has failed. The load/store pipeline pulses a fail strobe and supplies several things alongside it: the regime level that owns the translation, whether the access came from the user level, whether the regime has two address ranges, the store/load flag, the faulting virtual address and the 64-bit system control value of that regime. From these the unit selects a two-bit fault mode. Depending on the mode, it either requests a synchronous data abort or records the failure in a sticky per-level status entry. Exception delivery itself belongs to other logic.

A synchronous abort is a one-cycle request, `abort_o`. With it come a syndrome and the faulting address, and these are held until the next abort. An asynchronous failure sets one bit of a two-bit status entry chosen by level. Which bit is set depends on the upper/lower address range of the faulting address. The entries are always visible on `flags_o`, and software empties an entry through a write-zero port.

Top module: `tcf_policy_unit`

## Requirements
- R1: After synchronous reset, `abort_o`, `abort_syn_o`, `abort_addr_o` and every status entry on `flags_o` are zero.
- R2: The fault mode is `ctrl_i[39:38]` when `is_user_i` is 1, and `ctrl_i[41:40]` otherwise. The other field has no effect.
- R3: A fail strobe in mode 0 is ignored: there is no abort and no status bit changes.
- R4: In mode 1 every failing access, load or store, raises `abort_o` in the cycle after the strobe is sampled, for exactly one cycle per strobe.
- R5: In mode 2 a failure sets a status bit and never raises `abort_o`.
- R6: In mode 3 a store (`is_store_i`=1) sets a status bit without an abort, and a load raises an abort without touching status.
- R7: The status bit set is bit 1 of the entry when `two_range_i` is 1 and `fault_addr_i[55]` is 1. Otherwise it is bit 0.
- R8: The status entry used is entry 0 for user accesses and entry `regime_lvl_i` otherwise. Entry k sits at `flags_o[2k+1:2k]`.
- R9: At an abort, `abort_syn_o[5:0]` = 6'h11 and `abort_syn_o[6]` = `is_store_i`, and `abort_addr_o` = `fault_addr_i`. Both come from the failing access and hold until the next abort.
- R10: Status bits are sticky: they are ORed in and stay set. A clear (`clr_en_i`) zeroes entry `clr_lvl_i`. If a bit is set in the same entry and the same cycle as a clear, that bit survives and the entry's other bit is cleared.
- R11: With `fail_i` low, no abort is raised and no status bit is set, whatever the mode field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fail_i | input | 1 | Tag check failure strobe |
| is_user_i | input | 1 | Access made from the user level |
| regime_lvl_i | input | 2 | Level owning the translation regime |
| two_range_i | input | 1 | Regime has upper and lower address ranges |
| is_store_i | input | 1 | 1 for store, 0 for load |
| fault_addr_i | input | 64 | Faulting virtual address |
| ctrl_i | input | 64 | System control value of the regime |
| clr_en_i | input | 1 | Write-zero strobe for one status entry |
| clr_lvl_i | input | 2 | Entry to clear |
| abort_o | output | 1 | One-cycle synchronous abort request |
| abort_syn_o | output | 7 | Abort syndrome (status code, write flag) |
| abort_addr_o | output | 64 | Faulting address of the last abort |
| flags_o | output | 8 | Four sticky two-bit status entries |

## Verification
The hardest case to reach is a failure that sets one status bit in the same cycle that software clears the same entry. It needs an entry already holding the opposite bit, a fail strobe in mode 2 or mode 3-store, and a clear strobe, all aligned on one edge. The bench first sets bit 0 of an entry in one pass. It then issues a clear and an upper-range failure together on that entry, and expects only bit 1 to remain. Mode 3 is driven with both access directions on the same control value, to show the load/store split.

// File: rtl/tcf_pkg.sv
package tcf_pkg;

  typedef enum logic [1:0] {
    TCF_IGNORE = 2'd0,
    TCF_SYNC   = 2'd1,
    TCF_ASYNC  = 2'd2,
    TCF_SPLIT  = 2'd3
  } tcf_mode_e;

  localparam int          SYN_W    = 7;
  localparam logic [5:0]  TAG_FSC  = 6'h11;

  typedef struct packed {
    logic       wnr;
    logic [5:0] fsc;
  } tcf_syn_t;

endpackage

// File: rtl/tcf_mode_select.sv
module tcf_mode_select
  import tcf_pkg::*;
#(
  parameter int CTRL_W   = 64,
  parameter int USER_LSB = 38,
  parameter int PRIV_LSB = 40
) (
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              is_user,
  output tcf_mode_e         mode
);

  logic [1:0] user_fld;
  logic [1:0] priv_fld;
  logic       ctrl_unused;

  assign user_fld    = ctrl[USER_LSB +: 2];
  assign priv_fld    = ctrl[PRIV_LSB +: 2];
  assign ctrl_unused = ^ctrl;
  assign mode        = tcf_mode_e'(is_user ? user_fld : priv_fld);

endmodule

// File: rtl/tcf_action.sv
module tcf_action
  import tcf_pkg::*;
#(
  parameter int LVL_W = 2
) (
  input  logic             fail,
  input  tcf_mode_e        mode,
  input  logic             is_user,
  input  logic [LVL_W-1:0] lvl,
  input  logic             two_range,
  input  logic             upper_sel,
  input  logic             is_store,
  output logic             do_abort,
  output logic             do_flag,
  output logic [LVL_W-1:0] flag_idx,
  output logic [1:0]       flag_mask
);

  always_comb begin
    do_abort = 1'b0;
    do_flag  = 1'b0;
    if (fail) begin
      unique case (mode)
        TCF_IGNORE: ;
        TCF_SYNC:   do_abort = 1'b1;
        TCF_ASYNC:  do_flag  = 1'b1;
        TCF_SPLIT: begin
          do_flag  = is_store;
          do_abort = ~is_store;
        end
        default: ;
      endcase
    end
  end

  assign flag_idx  = is_user ? '0 : lvl;
  assign flag_mask = (two_range && upper_sel) ? 2'b10 : 2'b01;

endmodule

// File: rtl/tcf_status_bank.sv
module tcf_status_bank #(
  parameter int N_LVL = 4,
  parameter int LVL_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_en,
  input  logic [LVL_W-1:0]   set_idx,
  input  logic [1:0]         set_mask,
  input  logic               clr_en,
  input  logic [LVL_W-1:0]   clr_idx,
  output logic [2*N_LVL-1:0] flags
);

  for (genvar k = 0; k < N_LVL; k++) begin : g_entry
    logic [1:0] ent_q;
    logic       hit_set;
    logic       hit_clr;

    assign hit_set = set_en && (set_idx == LVL_W'(k));
    assign hit_clr = clr_en && (clr_idx == LVL_W'(k));

    always_ff @(posedge clk) begin
      if (rst) begin
        ent_q <= 2'b00;
      end else if (hit_set || hit_clr) begin
        ent_q <= (hit_clr ? 2'b00 : ent_q) | (hit_set ? set_mask : 2'b00);
      end
    end

    assign flags[2*k +: 2] = ent_q;
  end

endmodule

// File: rtl/tcf_abort_reg.sv
module tcf_abort_reg
  import tcf_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              is_store,
  input  logic [ADDR_W-1:0] addr,
  output logic              abort,
  output logic [SYN_W-1:0]  syn,
  output logic [ADDR_W-1:0] fault_addr
);

  tcf_syn_t syn_next;

  assign syn_next.wnr = is_store;
  assign syn_next.fsc = TAG_FSC;

  always_ff @(posedge clk) begin
    if (rst) begin
      abort      <= 1'b0;
      syn        <= '0;
      fault_addr <= '0;
    end else begin
      abort <= fire;
      if (fire) begin
        syn        <= syn_next;
        fault_addr <= addr;
      end
    end
  end

endmodule

// File: rtl/tcf_policy_unit.sv
module tcf_policy_unit
  import tcf_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int CTRL_W   = 64,
  parameter int N_LVL    = 4,
  parameter int SEL_BIT  = 55,
  parameter int USER_LSB = 38,
  parameter int PRIV_LSB = 40,
  parameter int LVL_W    = $clog2(N_LVL)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fail_i,
  input  logic               is_user_i,
  input  logic [LVL_W-1:0]   regime_lvl_i,
  input  logic               two_range_i,
  input  logic               is_store_i,
  input  logic [ADDR_W-1:0]  fault_addr_i,
  input  logic [CTRL_W-1:0]  ctrl_i,
  input  logic               clr_en_i,
  input  logic [LVL_W-1:0]   clr_lvl_i,
  output logic               abort_o,
  output logic [SYN_W-1:0]   abort_syn_o,
  output logic [ADDR_W-1:0]  abort_addr_o,
  output logic [2*N_LVL-1:0] flags_o
);

  tcf_mode_e        mode;
  logic             do_abort;
  logic             do_flag;
  logic [LVL_W-1:0] flag_idx;
  logic [1:0]       flag_mask;

  tcf_mode_select #(
    .CTRL_W  (CTRL_W),
    .USER_LSB(USER_LSB),
    .PRIV_LSB(PRIV_LSB)
  ) u_mode (
    .ctrl   (ctrl_i),
    .is_user(is_user_i),
    .mode   (mode)
  );

  tcf_action #(.LVL_W(LVL_W)) u_action (
    .fail     (fail_i),
    .mode     (mode),
    .is_user  (is_user_i),
    .lvl      (regime_lvl_i),
    .two_range(two_range_i),
    .upper_sel(fault_addr_i[SEL_BIT]),
    .is_store (is_store_i),
    .do_abort (do_abort),
    .do_flag  (do_flag),
    .flag_idx (flag_idx),
    .flag_mask(flag_mask)
  );

  tcf_status_bank #(.N_LVL(N_LVL), .LVL_W(LVL_W)) u_status (
    .clk     (clk),
    .rst     (rst),
    .set_en  (do_flag),
    .set_idx (flag_idx),
    .set_mask(flag_mask),
    .clr_en  (clr_en_i),
    .clr_idx (clr_lvl_i),
    .flags   (flags_o)
  );

  tcf_abort_reg #(.ADDR_W(ADDR_W)) u_abort (
    .clk       (clk),
    .rst       (rst),
    .fire      (do_abort),
    .is_store  (is_store_i),
    .addr      (fault_addr_i),
    .abort     (abort_o),
    .syn       (abort_syn_o),
    .fault_addr(abort_addr_o)
  );

endmodule

// File: rtl/tcf_policy_unit_chk.sv
module tcf_policy_unit_chk #(
  parameter int ADDR_W   = 64,
  parameter int CTRL_W   = 64,
  parameter int N_LVL    = 4,
  parameter int USER_LSB = 38,
  parameter int PRIV_LSB = 40,
  parameter int LVL_W    = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               fail_i,
  input logic               is_user_i,
  input logic [CTRL_W-1:0]  ctrl_i,
  input logic               clr_en_i,
  input logic [ADDR_W-1:0]  fault_addr_i,
  input logic               abort_o,
  input logic [6:0]         abort_syn_o,
  input logic [ADDR_W-1:0]  abort_addr_o,
  input logic [2*N_LVL-1:0] flags_o
);

  logic [1:0] fld;
  assign fld = is_user_i ? ctrl_i[USER_LSB +: 2] : ctrl_i[PRIV_LSB +: 2];

  // R4: an abort only follows a sampled strobe
  a_r4_abort_after_fail: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> $past(fail_i));

  // R3: mode 0 strobe leaves no trace
  a_r3_mode0_quiet: assert property (@(posedge clk) disable iff (rst)
    ($past(fail_i) && $past(fld) == 2'd0 && !$past(clr_en_i))
      |-> (!abort_o && flags_o == $past(flags_o)));

  // R5: mode 2 never aborts
  a_r5_async_no_abort: assert property (@(posedge clk) disable iff (rst)
    ($past(fail_i) && $past(fld) == 2'd2) |-> !abort_o);

  // R9: syndrome code and captured address
  a_r9_syn_code: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> (abort_syn_o[5:0] == 6'h11));

  a_r9_addr: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> (abort_addr_o == $past(fault_addr_i)));

  // R10: without a clear no set bit drops
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    !$past(clr_en_i) |-> ((flags_o & $past(flags_o)) == $past(flags_o)));

  // R7: at most one new bit per cycle
  a_r7_one_new_bit: assert property (@(posedge clk) disable iff (rst)
    $countones(flags_o & ~$past(flags_o)) <= 1);

  // R11: no strobe, no new bit and no abort
  a_r11_idle: assert property (@(posedge clk) disable iff (rst)
    !$past(fail_i) |-> (!abort_o && ((flags_o & ~$past(flags_o)) == '0)));

endmodule

bind tcf_policy_unit tcf_policy_unit_chk #(
  .ADDR_W  (ADDR_W),
  .CTRL_W  (CTRL_W),
  .N_LVL   (N_LVL),
  .USER_LSB(USER_LSB),
  .PRIV_LSB(PRIV_LSB),
  .LVL_W   (LVL_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .fail_i      (fail_i),
  .is_user_i   (is_user_i),
  .ctrl_i      (ctrl_i),
  .clr_en_i    (clr_en_i),
  .fault_addr_i(fault_addr_i),
  .abort_o     (abort_o),
  .abort_syn_o (abort_syn_o),
  .abort_addr_o(abort_addr_o),
  .flags_o     (flags_o)
);

// File: tb/tb_tcf_policy_unit.sv
module tb_tcf_policy_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fail_i = 1'b0;
  logic        is_user_i = 1'b0;
  logic [1:0]  regime_lvl_i = 2'd0;
  logic        two_range_i = 1'b0;
  logic        is_store_i = 1'b0;
  logic [63:0] fault_addr_i = '0;
  logic [63:0] ctrl_i = '0;
  logic        clr_en_i = 1'b0;
  logic [1:0]  clr_lvl_i = 2'd0;
  logic        abort_o;
  logic [6:0]  abort_syn_o;
  logic [63:0] abort_addr_o;
  logic [7:0]  flags_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_flags = '0;

  always #4 clk = ~clk;

  tcf_policy_unit dut (
    .clk(clk), .rst(rst), .fail_i(fail_i), .is_user_i(is_user_i),
    .regime_lvl_i(regime_lvl_i), .two_range_i(two_range_i),
    .is_store_i(is_store_i), .fault_addr_i(fault_addr_i), .ctrl_i(ctrl_i),
    .clr_en_i(clr_en_i), .clr_lvl_i(clr_lvl_i), .abort_o(abort_o),
    .abort_syn_o(abort_syn_o), .abort_addr_o(abort_addr_o), .flags_o(flags_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_ctrl(input logic [1:0] user_m, input logic [1:0] priv_m);
    logic [63:0] c = 64'hA5A5_F0F0_0000_1234;
    c[39:38] = user_m;
    c[41:40] = priv_m;
    return c;
  endfunction

  // One strobe cycle; returns at the negedge after the capturing edge.
  task automatic fire(input logic user, input logic [1:0] lvl, input logic two,
                      input logic st, input logic [63:0] addr, input logic [63:0] c,
                      input logic clr, input logic [1:0] clvl, input logic strobe);
    @(negedge clk);
    fail_i = strobe; is_user_i = user; regime_lvl_i = lvl; two_range_i = two;
    is_store_i = st; fault_addr_i = addr; ctrl_i = c; clr_en_i = clr; clr_lvl_i = clvl;
    @(negedge clk);
    fail_i = 1'b0; clr_en_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 abort", {63'd0, abort_o}, 64'd0);
    chk("R1 flags", {56'd0, flags_o}, 64'd0);
    chk("R1 syn", {57'd0, abort_syn_o}, 64'd0);
    chk("R1 addr", abort_addr_o, 64'd0);
  endtask

  task automatic t_field_select;
    // user access, user field = 1 -> abort; priv field 0 ignored
    fire(1'b1, 2'd2, 1'b0, 1'b0, 64'h1000, mk_ctrl(2'd1, 2'd0), 1'b0, 2'd0, 1'b1);
    chk("R2 user field picks mode1", {63'd0, abort_o}, 64'd1);
    chk("R4 load syndrome", {57'd0, abort_syn_o}, 64'h11);
    @(negedge clk);
    chk("R4 pulse one cycle", {63'd0, abort_o}, 64'd0);
    // user access, user field 0, priv field 1 -> nothing
    fire(1'b1, 2'd1, 1'b1, 1'b1, 64'h0080_0000_0000_0000, mk_ctrl(2'd0, 2'd1), 1'b0, 2'd0, 1'b1);
    chk("R2/R3 user mode0 no abort", {63'd0, abort_o}, 64'd0);
    chk("R3 user mode0 flags", {56'd0, flags_o}, {56'd0, exp_flags});
  endtask

  task automatic t_sync_store;
    fire(1'b0, 2'd2, 1'b1, 1'b1, 64'hDEAD_BEEF_0000_0040, mk_ctrl(2'd2, 2'd1), 1'b0, 2'd0, 1'b1);
    chk("R4 store abort", {63'd0, abort_o}, 64'd1);
    chk("R9 syndrome store", {57'd0, abort_syn_o}, 64'h51);
    chk("R9 addr", abort_addr_o, 64'hDEAD_BEEF_0000_0040);
    chk("R4 no flag on abort", {56'd0, flags_o}, {56'd0, exp_flags});
    @(negedge clk);
    chk("R4 pulse drops", {63'd0, abort_o}, 64'd0);
    chk("R9 syndrome held", {57'd0, abort_syn_o}, 64'h51);
    chk("R9 addr held", abort_addr_o, 64'hDEAD_BEEF_0000_0040);
  endtask

  task automatic t_async;
    fire(1'b0, 2'd1, 1'b1, 1'b0, 64'h0080_0000_0000_0000, mk_ctrl(2'd1, 2'd2), 1'b0, 2'd0, 1'b1);
    exp_flags[3] = 1'b1;
    chk("R5 mode2 no abort", {63'd0, abort_o}, 64'd0);
    chk("R7/R8 upper bit entry1", {56'd0, flags_o}, {56'd0, exp_flags});
    fire(1'b0, 2'd1, 1'b0, 1'b0, 64'h0080_0000_0000_0000, mk_ctrl(2'd1, 2'd2), 1'b0, 2'd0, 1'b1);
    exp_flags[2] = 1'b1;
    chk("R7/R10 single range uses bit0, sticky", {56'd0, flags_o}, {56'd0, exp_flags});
    fire(1'b1, 2'd2, 1'b1, 1'b1, 64'h0, mk_ctrl(2'd2, 2'd0), 1'b0, 2'd0, 1'b1);
    exp_flags[0] = 1'b1;
    chk("R8 user goes to entry0", {56'd0, flags_o}, {56'd0, exp_flags});
  endtask

  task automatic t_split;
    fire(1'b0, 2'd3, 1'b0, 1'b1, 64'h2000, mk_ctrl(2'd0, 2'd3), 1'b0, 2'd0, 1'b1);
    exp_flags[6] = 1'b1;
    chk("R6 store sets flag", {56'd0, flags_o}, {56'd0, exp_flags});
    chk("R6 store no abort", {63'd0, abort_o}, 64'd0);
    fire(1'b0, 2'd3, 1'b0, 1'b0, 64'h3000, mk_ctrl(2'd0, 2'd3), 1'b0, 2'd0, 1'b1);
    chk("R6 load aborts", {63'd0, abort_o}, 64'd1);
    chk("R6 load syndrome", {57'd0, abort_syn_o}, 64'h11);
    chk("R6 load no flag", {56'd0, flags_o}, {56'd0, exp_flags});
  endtask

  task automatic t_idle;
    fire(1'b0, 2'd2, 1'b1, 1'b0, 64'h0080_0000_0000_0000, mk_ctrl(2'd1, 2'd1), 1'b0, 2'd0, 1'b0);
    chk("R11 no strobe no abort", {63'd0, abort_o}, 64'd0);
    fire(1'b0, 2'd2, 1'b1, 1'b1, 64'h0080_0000_0000_0000, mk_ctrl(2'd2, 2'd2), 1'b0, 2'd0, 1'b0);
    chk("R11 no strobe no flag", {56'd0, flags_o}, {56'd0, exp_flags});
  endtask

  task automatic t_clear;
    fire(1'b0, 2'd0, 1'b0, 1'b0, 64'h0, 64'h0, 1'b1, 2'd1, 1'b0);
    exp_flags[3:2] = 2'b00;
    chk("R10 clear entry1 only", {56'd0, flags_o}, {56'd0, exp_flags});
    // entry3 holds 01; set bit1 while clearing entry3
    fire(1'b0, 2'd3, 1'b1, 1'b1, 64'h0080_0000_0000_0000, mk_ctrl(2'd0, 2'd3), 1'b1, 2'd3, 1'b1);
    exp_flags[7:6] = 2'b10;
    chk("R10 set wins over clear", {56'd0, flags_o}, {56'd0, exp_flags});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_field_select();
    t_sync_store();
    t_async();
    t_split();
    t_idle();
    t_clear();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule